// File: doc/BRIEF.md
# Tournament Branch Direction Predictor

This block predicts whether a conditional branch will be taken. Two predictors run side by side. One is a table of 2-bit saturating counters indexed by the low bits of the branch address. The other is a table of the same kind, indexed by the global history XOR-ed with those address bits. A third table of 2-bit counters, indexed by the address, picks which of the two answers is the final prediction. That chooser is trained only when exactly one of the two predictors was right.

The global history register advances speculatively. Every accepted prediction shifts the predicted direction in at once, so back-to-back branches see up-to-date history. Each prediction returns the history it used as a checkpoint, along with both component predictions. The pipeline carries these to resolution and hands them back on the resolve port. The three counter tables change only at resolution. When a resolved branch was mispredicted, the history is rebuilt from the returned checkpoint with the real outcome appended.

Top module: `tourn_pred`

## Requirements
- R1: After reset the global history is all zeros, every bimodal and gshare counter holds 2'b10 (weakly taken) and every chooser counter holds 2'b01, so the first prediction reports taken on all three outputs with a zero checkpoint.
- R2: The bimodal counter at index res_ip[IDX_W-1:0] is updated on every valid resolve. It goes up on taken and down on not taken, saturating at 2'b11 and 2'b00. pred_bim is the most significant bit of the counter at pred_ip[IDX_W-1:0].
- R3: The gshare counter is read at index (effective history XOR pred_ip[IDX_W-1:0]). It is updated at index (res_ckpt XOR res_ip[IDX_W-1:0]) with the same saturating rule as R2. pred_gsh is its most significant bit.
- R4: On a valid resolve, the chooser counter at res_ip[IDX_W-1:0] goes up (saturating) when res_bim equals res_taken and res_gsh does not. It goes down (saturating) in the opposite case. It is unchanged when res_bim equals res_gsh.
- R5: pred_taken equals pred_bim when the chooser counter's most significant bit is 1, and pred_gsh when it is 0.
- R6: pred_ckpt is the history used for the current prediction. After a cycle with pred_valid high, the history becomes {pred_ckpt[IDX_W-2:0], pred_taken}.
- R7: A valid resolve with res_mispred high loads the history with {res_ckpt[IDX_W-2:0], res_taken}.
- R8: When a repair and a prediction occur in the same cycle, the prediction uses the repaired history. Its checkpoint is {res_ckpt[IDX_W-2:0], res_taken}, and the history then shifts in pred_taken on top of it.
- R9: With pred_valid low and no mispredicted resolve, the history is unchanged. A correctly predicted resolve has no effect on it.
- R10: A prediction and a resolve in the same cycle read the counters as they stood before that resolve's update.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| pred_valid | input | 1 | A prediction is consumed this cycle; history shifts |
| pred_ip | input | IP_W | Address of the branch being predicted |
| pred_taken | output | 1 | Final predicted direction |
| pred_bim | output | 1 | Bimodal component prediction |
| pred_gsh | output | 1 | Gshare component prediction |
| pred_ckpt | output | IDX_W | History used for this prediction |
| res_valid | input | 1 | A branch resolves this cycle |
| res_ip | input | IP_W | Address of the resolving branch |
| res_taken | input | 1 | Actual outcome |
| res_mispred | input | 1 | Final prediction was wrong; repair history |
| res_ckpt | input | IDX_W | Checkpoint returned with the prediction |
| res_bim | input | 1 | Bimodal prediction returned with the prediction |
| res_gsh | input | 1 | Gshare prediction returned with the prediction |

## Verification
The assertions check on every cycle how the history register moves: a speculative shift, a repair load, or a hold. They also check that a saturated counter stays at its limit and that a prediction follows both components whenever they agree. Only the bench scenarios can show the table contents. The bench compares every output against a shadow model of all three tables over random traffic with colliding addresses. Directed cases cover chooser training, same-cycle repair with prediction, and same-cycle read with write.

// File: rtl/tp_pkg.sv
package tp_pkg;
  typedef logic [1:0] ctr_t;

  localparam ctr_t CTR_WEAK_TAKEN = 2'b10;
  localparam ctr_t CTR_WEAK_NOT   = 2'b01;
  localparam ctr_t CTR_MAX        = 2'b11;
  localparam ctr_t CTR_MIN        = 2'b00;

  // Saturating up/down step of a 2-bit counter
  function automatic ctr_t ctr_step(ctr_t c, logic up);
    ctr_t r;
    if (up) r = (c == CTR_MAX) ? CTR_MAX : c + 2'd1;
    else    r = (c == CTR_MIN) ? CTR_MIN : c - 2'd1;
    return r;
  endfunction
endpackage

// File: rtl/tp_ctr_table.sv
module tp_ctr_table
  import tp_pkg::*;
#(
  parameter int   IDX_W   = 10,
  parameter ctr_t RST_VAL = CTR_WEAK_TAKEN
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [IDX_W-1:0] rd_idx,
  output logic             rd_msb,
  input  logic             wr_en,
  input  logic [IDX_W-1:0] wr_idx,
  input  logic             wr_up
);
  localparam int DEPTH = 1 << IDX_W;

  ctr_t cnt_q [DEPTH];
  ctr_t cnt_d [DEPTH];

  for (genvar g = 0; g < DEPTH; g++) begin : g_ent
    logic hit;
    assign hit = wr_en && (wr_idx == IDX_W'(g));

    always_comb begin
      cnt_d[g] = ctr_step(cnt_q[g], wr_up);
    end

    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)   cnt_q[g] <= RST_VAL;
      else if (hit) cnt_q[g] <= cnt_d[g];
    end
  end

  assign rd_msb = cnt_q[rd_idx][1];

  AST_CTR_CEIL: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_en && wr_up && cnt_q[wr_idx] == CTR_MAX) |=> (cnt_q[$past(wr_idx)] == CTR_MAX)); // R2
  AST_CTR_FLOOR: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_en && !wr_up && cnt_q[wr_idx] == CTR_MIN) |=> (cnt_q[$past(wr_idx)] == CTR_MIN)); // R2
endmodule

// File: rtl/tp_ghist.sv
module tp_ghist #(
  parameter int W = 10
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         spec_en,
  input  logic         spec_dir,
  input  logic         fix_en,
  input  logic [W-2:0] fix_ckpt,
  input  logic         fix_dir,
  output logic [W-1:0] hist_cur
);
  logic [W-1:0] hist_q;
  logic [W-1:0] hist_d;
  logic         hist_ce;

  // Repair takes priority and is visible to a same-cycle prediction
  always_comb begin
    hist_cur = fix_en ? {fix_ckpt, fix_dir} : hist_q;
    hist_d   = spec_en ? {hist_cur[W-2:0], spec_dir} : hist_cur;
    hist_ce  = spec_en || fix_en;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)       hist_q <= '0;
    else if (hist_ce) hist_q <= hist_d;
  end

  AST_SPEC_SHIFT: assert property (@(posedge clk) disable iff (!rst_n)
    (spec_en && !fix_en) |=> (hist_q == {$past(hist_q[W-2:0]), $past(spec_dir)})); // R6
  AST_REPAIR_LOAD: assert property (@(posedge clk) disable iff (!rst_n)
    (fix_en && !spec_en) |=> (hist_q == {$past(fix_ckpt), $past(fix_dir)})); // R7
  AST_REPAIR_THEN_SHIFT: assert property (@(posedge clk) disable iff (!rst_n)
    (fix_en && spec_en) |=> (hist_q == {$past(fix_ckpt[W-3:0]), $past(fix_dir), $past(spec_dir)})); // R8
  AST_HIST_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    (!fix_en && !spec_en) |=> $stable(hist_q)); // R9
endmodule

// File: rtl/tourn_pred.sv
module tourn_pred
  import tp_pkg::*;
#(
  parameter int IP_W  = 32,
  parameter int IDX_W = 10
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             pred_valid,
  input  logic [IP_W-1:0]  pred_ip,
  output logic             pred_taken,
  output logic             pred_bim,
  output logic             pred_gsh,
  output logic [IDX_W-1:0] pred_ckpt,
  input  logic             res_valid,
  input  logic [IP_W-1:0]  res_ip,
  input  logic             res_taken,
  input  logic             res_mispred,
  input  logic [IDX_W-1:0] res_ckpt,
  input  logic             res_bim,
  input  logic             res_gsh
);
  logic [IDX_W-1:0] p_idx, r_idx, p_gidx, r_gidx;
  logic [IDX_W-1:0] hist_cur;
  logic             cho_msb;
  logic             fix_en;
  logic             cho_we, cho_up;
  logic             unused_ip_hi;

  assign p_idx  = pred_ip[IDX_W-1:0];
  assign r_idx  = res_ip[IDX_W-1:0];
  assign p_gidx = hist_cur ^ p_idx;
  assign r_gidx = res_ckpt ^ r_idx;
  assign fix_en = res_valid && res_mispred;
  assign cho_we = res_valid && (res_bim != res_gsh);
  assign cho_up = (res_bim == res_taken);
  assign unused_ip_hi = ^{pred_ip[IP_W-1:IDX_W], res_ip[IP_W-1:IDX_W]};

  tp_ghist #(.W(IDX_W)) u_hist (
    .clk      (clk),
    .rst_n    (rst_n),
    .spec_en  (pred_valid),
    .spec_dir (pred_taken),
    .fix_en   (fix_en),
    .fix_ckpt (res_ckpt[IDX_W-2:0]),
    .fix_dir  (res_taken),
    .hist_cur (hist_cur)
  );

  tp_ctr_table #(.IDX_W(IDX_W), .RST_VAL(CTR_WEAK_TAKEN)) u_bim (
    .clk    (clk),
    .rst_n  (rst_n),
    .rd_idx (p_idx),
    .rd_msb (pred_bim),
    .wr_en  (res_valid),
    .wr_idx (r_idx),
    .wr_up  (res_taken)
  );

  tp_ctr_table #(.IDX_W(IDX_W), .RST_VAL(CTR_WEAK_TAKEN)) u_gsh (
    .clk    (clk),
    .rst_n  (rst_n),
    .rd_idx (p_gidx),
    .rd_msb (pred_gsh),
    .wr_en  (res_valid),
    .wr_idx (r_gidx),
    .wr_up  (res_taken)
  );

  tp_ctr_table #(.IDX_W(IDX_W), .RST_VAL(CTR_WEAK_NOT)) u_cho (
    .clk    (clk),
    .rst_n  (rst_n),
    .rd_idx (p_idx),
    .rd_msb (cho_msb),
    .wr_en  (cho_we),
    .wr_idx (r_idx),
    .wr_up  (cho_up)
  );

  assign pred_taken = cho_msb ? pred_bim : pred_gsh;
  assign pred_ckpt  = hist_cur;

  AST_AGREE_FOLLOWS: assert property (@(posedge clk) disable iff (!rst_n)
    (pred_bim == pred_gsh) |-> (pred_taken == pred_bim)); // R5
  AST_REPAIR_CKPT: assert property (@(posedge clk) disable iff (!rst_n)
    (res_valid && res_mispred) |-> (pred_ckpt == {res_ckpt[IDX_W-2:0], res_taken})); // R8
endmodule

// File: tb/tourn_pred_tb_top.sv
module tourn_pred_tb_top;
  localparam int IW    = 16;
  localparam int W     = 6;
  localparam int DEPTH = 1 << W;

  logic          clk = 1'b0;
  logic          rst_n;
  logic          pred_valid;
  logic [IW-1:0] pred_ip;
  logic          pred_taken, pred_bim, pred_gsh;
  logic [W-1:0]  pred_ckpt;
  logic          res_valid;
  logic [IW-1:0] res_ip;
  logic          res_taken, res_mispred, res_bim, res_gsh;
  logic [W-1:0]  res_ckpt;

  int checks = 0;
  int errors = 0;
  bit done   = 0;

  always #4 clk = ~clk;

  tourn_pred #(.IP_W(IW), .IDX_W(W)) dut_i (
    .clk(clk), .rst_n(rst_n),
    .pred_valid(pred_valid), .pred_ip(pred_ip),
    .pred_taken(pred_taken), .pred_bim(pred_bim), .pred_gsh(pred_gsh),
    .pred_ckpt(pred_ckpt),
    .res_valid(res_valid), .res_ip(res_ip), .res_taken(res_taken),
    .res_mispred(res_mispred), .res_ckpt(res_ckpt),
    .res_bim(res_bim), .res_gsh(res_gsh)
  );

  // Shadow model
  logic [1:0]   bim_m [DEPTH];
  logic [1:0]   gsh_m [DEPTH];
  logic [1:0]   cho_m [DEPTH];
  logic [W-1:0] hist_m;

  typedef struct packed {
    logic [IW-1:0] ip;
    logic [W-1:0]  ck;
    logic          b;
    logic          g;
    logic          t;
  } rec_t;
  rec_t inflight [$];
  rec_t last_pred;

  function automatic logic [1:0] m_up(logic [1:0] c, logic up);
    if (up) return (c == 2'd3) ? 2'd3 : c + 2'd1;
    return (c == 2'd0) ? 2'd0 : c - 2'd1;
  endfunction

  task automatic chk(string req, int act, int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s: actual %0d expected %0d at %0t", req, act, exp, $time);
    end
  endtask

  // One cycle: drive, compare against model, advance model
  task automatic cyc(string ctx, logic pv, logic [IW-1:0] pip,
                     logic rv, logic [IW-1:0] rip, logic rt, logic rm,
                     logic [W-1:0] rck, logic rb, logic rg);
    logic [W-1:0] eff;
    logic eb, eg, ec, et;
    @(negedge clk);
    pred_valid = pv; pred_ip = pip;
    res_valid = rv; res_ip = rip; res_taken = rt; res_mispred = rm;
    res_ckpt = rck; res_bim = rb; res_gsh = rg;
    #1;
    eff = (rv && rm) ? {rck[W-2:0], rt} : hist_m;
    eb  = bim_m[pip[W-1:0]][1];
    eg  = gsh_m[eff ^ pip[W-1:0]][1];
    ec  = cho_m[pip[W-1:0]][1];
    et  = ec ? eb : eg;
    chk({ctx, " R6 ckpt"}, int'(pred_ckpt), int'(eff));
    chk({ctx, " R2 bim"},  int'(pred_bim),  int'(eb));
    chk({ctx, " R3 gsh"},  int'(pred_gsh),  int'(eg));
    chk({ctx, " R5 final"}, int'(pred_taken), int'(et));
    last_pred = '{ip: pip, ck: eff, b: eb, g: eg, t: et};
    // R10: reads above used pre-update state; now apply resolve
    if (rv) begin
      bim_m[rip[W-1:0]] = m_up(bim_m[rip[W-1:0]], rt);
      gsh_m[rck ^ rip[W-1:0]] = m_up(gsh_m[rck ^ rip[W-1:0]], rt);
      if (rb != rg) cho_m[rip[W-1:0]] = m_up(cho_m[rip[W-1:0]], rb == rt);
    end
    hist_m = pv ? {eff[W-2:0], et} : eff;
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    if (!done) begin
      errors++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

  initial begin
    void'($urandom(32'h5eed_1234));
    for (int i = 0; i < DEPTH; i++) begin
      bim_m[i] = 2'b10; gsh_m[i] = 2'b10; cho_m[i] = 2'b01;
    end
    hist_m = '0;
    rst_n = 1'b0;
    pred_valid = 0; pred_ip = '0; res_valid = 0; res_ip = '0;
    res_taken = 0; res_mispred = 0; res_ckpt = '0; res_bim = 0; res_gsh = 0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;

    // R1: reset state, first prediction taken with zero checkpoint
    #1;
    chk("R1 taken", int'(pred_taken), 1);
    chk("R1 bim", int'(pred_bim), 1);
    chk("R1 gsh", int'(pred_gsh), 1);
    chk("R1 ckpt", int'(pred_ckpt), 0);

    // R2: saturate bimodal at ip 5 upward, then one down stays taken
    for (int k = 0; k < 3; k++) cyc("R2 up", 0, 16'd5, 1, 16'd5, 1, 0, 6'd0, 1, 1);
    cyc("R2 down1", 0, 16'd5, 1, 16'd5, 0, 0, 6'd0, 1, 1);
    cyc("R2 hold", 0, 16'd5, 0, 16'd0, 0, 0, 6'd0, 0, 0);
    chk("R2 sat msb", int'(pred_bim), 1);
    for (int k = 0; k < 4; k++) cyc("R2 dn", 0, 16'd5, 1, 16'd5, 0, 0, 6'd0, 1, 1);
    cyc("R2 floor", 0, 16'd5, 0, 16'd0, 0, 0, 6'd0, 0, 0);
    chk("R2 floor msb", int'(pred_bim), 0);

    // R4: chooser at ip 3 trained toward bimodal, then unchanged on agreement
    cyc("R4 inc", 0, 16'd3, 1, 16'd3, 1, 0, 6'd0, 1, 0);
    cyc("R4 same", 0, 16'd3, 1, 16'd3, 0, 0, 6'd0, 0, 0);
    cyc("R4 look", 0, 16'd3, 0, 16'd0, 0, 0, 6'd0, 0, 0);
    cyc("R4 dec", 0, 16'd3, 1, 16'd3, 1, 0, 6'd0, 0, 1);
    cyc("R4 look2", 0, 16'd3, 0, 16'd0, 0, 0, 6'd0, 0, 0);

    // R6: speculative shifts
    cyc("R6 spec", 1, 16'd9, 0, 16'd0, 0, 0, 6'd0, 0, 0);
    cyc("R6 spec", 1, 16'd10, 0, 16'd0, 0, 0, 6'd0, 0, 0);
    // R9: correct resolve leaves history alone
    cyc("R9 hold", 0, 16'd9, 1, 16'd9, 1, 0, 6'd0, 1, 1);
    cyc("R9 look", 0, 16'd9, 0, 16'd0, 0, 0, 6'd0, 0, 0);
    // R7: repair alone
    cyc("R7 fix", 0, 16'd1, 1, 16'd1, 0, 1, 6'b101010, 1, 1);
    cyc("R7 look", 0, 16'd1, 0, 16'd0, 0, 0, 6'd0, 0, 0);
    chk("R7 repaired", int'(pred_ckpt), int'(6'b010100));
    // R8: repair and prediction together
    cyc("R8 both", 1, 16'd2, 1, 16'd2, 1, 1, 6'b110011, 0, 1);
    chk("R8 ckpt", int'(pred_ckpt), int'(6'b100111));
    cyc("R8 look", 0, 16'd2, 0, 16'd0, 0, 0, 6'd0, 0, 0);
    // R10: same-cycle resolve and predict on one address
    cyc("R10 rw", 1, 16'd5, 1, 16'd5, 1, 0, 6'd0, 0, 0);
    cyc("R10 after", 0, 16'd5, 0, 16'd0, 0, 0, 6'd0, 0, 0);

    // Random traffic with in-flight branches and colliding addresses
    for (int n = 0; n < 3000; n++) begin
      logic pv, rv, rt;
      logic [IW-1:0] pip;
      rec_t r;
      pv  = ($urandom % 10) < 7;
      pip = ($urandom % 4 == 0) ? IW'($urandom) : IW'($urandom % 12);
      rv  = (inflight.size() > 0) && ($urandom % 2 == 0);
      r   = '0;
      if (rv) r = inflight.pop_front();
      rt  = (r.ip[0]) ? ($urandom % 8 != 0) : ($urandom % 3 == 0);
      cyc("rand", pv, pip, rv, r.ip, rt, rv && (rt != r.t), r.ck, r.b, r.g);
      if (pv) inflight.push_back(last_pred);
      if (rv && (rt != r.t)) inflight.delete();
    end

    done = 1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule